// File: doc/BRIEF.md
# Trigger Record FIFO Writer

This block sits between the level-1 trigger generator and the FIFO that feeds a serial readout link. Each time an accept pulse arrives, it takes the event number and the bunch-crossing number that come with it and packs them into a 64-bit trigger record. It then writes that record into the downstream FIFO.

The FIFO full flag acts as back-pressure, but the writer never stalls the trigger stream. The flag is sampled in the same cycle as the accept. If the flag is low, the record is written one cycle later. If the flag is high, the record is discarded for good and a saturating drop counter is incremented. Downstream logic can read that counter to learn how many records the readout path lost.

Top module: `trig_rec_writer`

## Requirements
- R1: While reset (active-low, synchronous) is held, and in the first cycle after it, the write enable is 0, the record word is all zeros and the drop count is 0.
- R2: Record bits 11:0 carry the 12-bit bunch-crossing number presented with the accept.
- R3: Record bits 31:12 carry the low 20 bits of the event number presented with the accept.
- R4: Record bits 63:32 are always zero.
- R5: An accept seen with the full flag low produces a write enable that is high for exactly one cycle, in the cycle after the accept, with the record valid in that same cycle.
- R6: An accept seen with the full flag high produces no write, either then or later; the record is never retried.
- R7: Each accept seen with the full flag high adds exactly one to the drop count, visible in the cycle after the accept.
- R8: The drop count saturates at its all-ones value and stays there.
- R9: In a cycle without an accept, no write follows and the drop count does not change.
- R10: The record output changes only when a write is issued; otherwise it holds the last written record.
- R11: Against a 1024-entry FIFO that never drains, exactly 1024 records are written, and every later accept is counted as dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| accept_i | input | 1 | Level-1 accept strobe, one cycle per trigger |
| evt_num_i | input | EVT_IN_W (32) | Event number that comes with the accept |
| bx_num_i | input | BX_W (12) | Bunch-crossing number that comes with the accept |
| fifo_full_i | input | 1 | Full flag of the downstream FIFO (back-pressure) |
| rec_data_o | output | REC_W (64) | Packed trigger record |
| rec_wr_o | output | 1 | FIFO write enable |
| drop_count_o | output | CNT_W (32) | Number of records discarded because the FIFO was full |

## Verification
The assertions check several rules on every cycle:
- the one-cycle relation between an accept and its write or drop;
- the packed field contents of each written record;
- the zero upper word;
- that the record holds between writes;
- that the counter steps by one, stays flat without a drop, and sticks at its maximum.

Other behaviour can only be shown by the bench's scenarios. These include the fill of a never-draining 1024-entry FIFO, which must end with exactly 1024 writes and every later accept dropped. They also include the absence of any late retry several cycles after a drop, and saturation reached through a narrow counter instance.

// File: rtl/trig_rec_pkg.sv
package trig_rec_pkg;
    localparam int REC_W       = 64;
    localparam int BX_W        = 12;
    localparam int EVT_FIELD_W = 20;
    localparam int EVT_IN_W    = 32;
    localparam int CNT_W       = 32;
endpackage

// File: rtl/trig_rec_pack.sv
module trig_rec_pack #(
    parameter int EVT_IN_W    = 32,
    parameter int BX_W        = 12,
    parameter int EVT_FIELD_W = 20,
    parameter int REC_W       = 64
) (
    input  logic [EVT_IN_W-1:0] evt_num_i,
    input  logic [BX_W-1:0]     bx_num_i,
    output logic [REC_W-1:0]    record_o
);
    localparam int USED_W = EVT_FIELD_W + BX_W;
    localparam int PAD_W  = REC_W - USED_W;

    logic [USED_W-1:0] payload;
    assign payload = {evt_num_i[EVT_FIELD_W-1:0], bx_num_i};

    generate
        if (PAD_W > 0) begin : g_padded
            assign record_o = {{PAD_W{1'b0}}, payload};
        end else begin : g_exact
            assign record_o = payload[REC_W-1:0];
        end
    endgenerate
endmodule

// File: rtl/drop_counter.sv
module drop_counter #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             inc_i,
    output logic [CNT_W-1:0] count_o
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } cnt_state_t;

    cnt_state_t state_d, state_q;

    always_comb begin
        state_d = state_q;
        if (inc_i && (state_q.cnt != CNT_MAX)) begin
            state_d.cnt = state_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign count_o = state_q.cnt;

    assert_step_one_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (inc_i && count_o != CNT_MAX) |=> (count_o == $past(count_o) + 1'b1));

    assert_sticks_at_max_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (count_o == CNT_MAX) |=> (count_o == CNT_MAX));

    assert_flat_when_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !inc_i |=> $stable(count_o));
endmodule

// File: rtl/trig_rec_writer.sv
module trig_rec_writer
    import trig_rec_pkg::*;
#(
    parameter int P_EVT_IN_W    = EVT_IN_W,
    parameter int P_BX_W        = BX_W,
    parameter int P_EVT_FIELD_W = EVT_FIELD_W,
    parameter int P_REC_W       = REC_W,
    parameter int P_CNT_W       = CNT_W
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    accept_i,
    input  logic [P_EVT_IN_W-1:0]   evt_num_i,
    input  logic [P_BX_W-1:0]       bx_num_i,
    input  logic                    fifo_full_i,
    output logic [P_REC_W-1:0]      rec_data_o,
    output logic                    rec_wr_o,
    output logic [P_CNT_W-1:0]      drop_count_o
);
    localparam int HI_W = P_REC_W - P_EVT_FIELD_W - P_BX_W;

    typedef struct packed {
        logic               wr;
        logic [P_REC_W-1:0] data;
    } wr_state_t;

    wr_state_t        state_d, state_q;
    logic [P_REC_W-1:0] packed_rec;
    logic             take;
    logic             drop;

    trig_rec_pack #(
        .EVT_IN_W    (P_EVT_IN_W),
        .BX_W        (P_BX_W),
        .EVT_FIELD_W (P_EVT_FIELD_W),
        .REC_W       (P_REC_W)
    ) u_pack (
        .evt_num_i (evt_num_i),
        .bx_num_i  (bx_num_i),
        .record_o  (packed_rec)
    );

    always_comb begin
        take    = accept_i && !fifo_full_i;
        drop    = accept_i &&  fifo_full_i;
        state_d = state_q;
        state_d.wr = take;
        if (take) begin
            state_d.data = packed_rec;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    drop_counter #(
        .CNT_W (P_CNT_W)
    ) u_drops (
        .clk     (clk),
        .rst_n   (rst_n),
        .inc_i   (drop),
        .count_o (drop_count_o)
    );

    assign rec_wr_o   = state_q.wr;
    assign rec_data_o = state_q.data;

    assert_write_after_take_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (accept_i && !fifo_full_i) |=> rec_wr_o);

    assert_fields_R2_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (accept_i && !fifo_full_i) |=>
            (rec_data_o[P_BX_W-1:0] == $past(bx_num_i)) &&
            (rec_data_o[P_BX_W+P_EVT_FIELD_W-1:P_BX_W] == $past(evt_num_i[P_EVT_FIELD_W-1:0])));

    assert_no_write_when_full_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (accept_i && fifo_full_i) |=> !rec_wr_o);

    assert_no_write_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !accept_i |=> !rec_wr_o);

    assert_hold_between_writes_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !(accept_i && !fifo_full_i) |=> $stable(rec_data_o));

    assert_upper_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
        rec_data_o[P_REC_W-1:P_REC_W-HI_W] == '0);
endmodule

// File: tb/trig_rec_writer_tb.sv
`timescale 1ns/1ps
module trig_rec_writer_tb;
    localparam int FIFO_DEPTH = 1024;
    localparam int EXTRA      = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        accept = 1'b0;
    logic [31:0] evt = '0;
    logic [11:0] bx = '0;
    logic        full = 1'b0;
    logic [63:0] data;
    logic        wr;
    logic [31:0] drops;
    logic [63:0] sat_data;
    logic        sat_wr;
    logic [2:0]  sat_drops;

    int checks = 0;
    int failures = 0;

    always #4 clk = ~clk;

    trig_rec_writer u_dut (
        .clk(clk), .rst_n(rst_n), .accept_i(accept), .evt_num_i(evt),
        .bx_num_i(bx), .fifo_full_i(full), .rec_data_o(data),
        .rec_wr_o(wr), .drop_count_o(drops)
    );

    trig_rec_writer #(.P_CNT_W(3)) u_dut_sat (
        .clk(clk), .rst_n(rst_n), .accept_i(accept), .evt_num_i(evt),
        .bx_num_i(bx), .fifo_full_i(1'b1), .rec_data_o(sat_data),
        .rec_wr_o(sat_wr), .drop_count_o(sat_drops)
    );

    typedef struct packed {
        logic [31:0] evt;
        logic [11:0] bx;
        logic        full;
    } vec_t;

    localparam vec_t VECS [8] = '{
        '{32'h0000_0001, 12'h000, 1'b0},
        '{32'hFFFF_FFFF, 12'hFFF, 1'b0},
        '{32'hABCD_E123, 12'hDEB, 1'b1},
        '{32'h1234_5678, 12'h9AB, 1'b0},
        '{32'h000F_FFFF, 12'h001, 1'b1},
        '{32'hFFF0_0000, 12'hDEB, 1'b0},
        '{32'h5555_AAAA, 12'h555, 1'b1},
        '{32'h8000_0000, 12'h800, 1'b0}
    };

    task automatic check(input bit ok, input string req, input logic [63:0] act,
                         input logic [63:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic report();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        accept = 1'b0;
        full = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        failures++;
        $display("FAIL watchdog actual=%h expected=%h", 64'd0, 64'd1);
        report();
    end

    initial begin
        logic [63:0] last_rec;
        logic [31:0] exp_drops;
        int fifo_cnt;
        int writes;

        // R1: reset values while held and right after release
        repeat (3) @(negedge clk);
        check(wr == 1'b0, "R1 wr in reset", {63'd0, wr}, 64'd0);
        check(data == 64'd0, "R1 data in reset", data, 64'd0);
        check(drops == 32'd0, "R1 drops in reset", {32'd0, drops}, 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check(wr == 1'b0 && data == 64'd0 && drops == 32'd0, "R1 after release",
              {wr, data[62:0]}, 64'd0);

        // Vector walk: R2 R3 R4 R5 R6 R7 R9 R10
        last_rec  = 64'd0;
        exp_drops = 32'd0;
        for (int i = 0; i < 8; i++) begin
            logic [63:0] exp_rec;
            accept = 1'b1;
            evt = VECS[i].evt;
            bx = VECS[i].bx;
            full = VECS[i].full;
            exp_rec = {32'd0, VECS[i].evt[19:0], VECS[i].bx};
            @(negedge clk);
            accept = 1'b0;
            full = 1'b0;
            if (!VECS[i].full) begin
                check(wr == 1'b1, "R5 write after accept", {63'd0, wr}, 64'd1);
                check(data[11:0] == exp_rec[11:0], "R2 bunch field", data, exp_rec);
                check(data[31:12] == exp_rec[31:12], "R3 event field", data, exp_rec);
                check(data[63:32] == 32'd0, "R4 upper zero", data, exp_rec);
                last_rec = exp_rec;
            end else begin
                exp_drops++;
                check(wr == 1'b0, "R6 no write when full", {63'd0, wr}, 64'd0);
                check(data == last_rec, "R10 record held on drop", data, last_rec);
            end
            check(drops == exp_drops, "R7 drop count", {32'd0, drops}, {32'd0, exp_drops});
            @(negedge clk);
            check(wr == 1'b0, "R5 single-cycle pulse / R6 no retry", {63'd0, wr}, 64'd0);
            check(drops == exp_drops, "R9 count flat when idle", {32'd0, drops},
                  {32'd0, exp_drops});
            check(data == last_rec, "R10 record held when idle", data, last_rec);
        end

        // R6: no late retry after a drop
        accept = 1'b1;
        full = 1'b1;
        evt = 32'hCAFE_0001;
        bx = 12'h123;
        @(negedge clk);
        accept = 1'b0;
        full = 1'b0;
        exp_drops++;
        for (int k = 0; k < 6; k++) begin
            check(wr == 1'b0, "R6 no retry later", {63'd0, wr}, 64'd0);
            @(negedge clk);
        end
        check(drops == exp_drops, "R7 drop after retry window", {32'd0, drops},
              {32'd0, exp_drops});

        // R11: fill a never-draining FIFO of 1024 entries
        do_reset();
        @(negedge clk);
        fifo_cnt = 0;
        writes = 0;
        for (int n = 0; n < FIFO_DEPTH + EXTRA; n++) begin
            accept = 1'b1;
            evt = n;
            bx = n[11:0];
            full = (fifo_cnt >= FIFO_DEPTH);
            @(negedge clk);
            accept = 1'b0;
            full = (fifo_cnt >= FIFO_DEPTH);
            if (wr) begin
                fifo_cnt++;
                writes++;
            end
            @(negedge clk);
        end
        check(writes == FIFO_DEPTH, "R11 records written", writes, FIFO_DEPTH);
        check(drops == EXTRA, "R11 later accepts dropped", {32'd0, drops}, EXTRA);
        check(data == {32'd0, 20'(FIFO_DEPTH - 1), 12'(FIFO_DEPTH - 1)},
              "R11 last stored record", data,
              {32'd0, 20'(FIFO_DEPTH - 1), 12'(FIFO_DEPTH - 1)});

        // R8: saturation on a 3-bit counter instance whose FIFO is always full
        do_reset();
        @(negedge clk);
        for (int s = 0; s < 10; s++) begin
            accept = 1'b1;
            @(negedge clk);
            accept = 1'b0;
            check(sat_drops == ((s + 1 > 7) ? 3'd7 : 3'(s + 1)), "R8 saturating count",
                  {61'd0, sat_drops}, (s + 1 > 7) ? 64'd7 : 64'(s + 1));
            check(sat_wr == 1'b0, "R6 always-full instance never writes",
                  {63'd0, sat_wr}, 64'd0);
        end

        // R1: reset clears a nonzero drop count
        do_reset();
        @(negedge clk);
        check(sat_drops == 3'd0 && drops == 32'd0, "R1 reset clears drops",
              {29'd0, sat_drops, drops}, 64'd0);

        report();
    end
endmodule